// File: doc/BRIEF.md
# Programmable Burst Timing Controller

This block paces a burst-mode transmitter one symbol at a time. Every burst is an optional preamble, then a data packet, then a silent guard interval. All timing advances only on a one-cycle symbol strobe, so the block runs at any symbol rate that the surrounding clock divider sets. A small write port programs five registers:

- the three phase lengths
- the number of bursts
- a control word holding auto-repeat, the preamble source and the operating mode

In master mode a start command begins the sequence, and each burst follows the previous guard interval with no gap. In slave mode the start command only arms the block. Each burst then waits for a rising edge on an external trigger.

The outputs are:

- an active-low data enable for the modulator
- its active-high copy, for use as a sync or gate
- a select that picks the internal preamble store while preamble symbols go out
- a done flag raised once the programmed number of bursts has been sent

Writes go to a shadow register set. That set is copied into the working set whenever a burst begins, so a burst in progress never changes shape.

Top module: `burst_seq_ctl`

## Requirements
- R1: After reset all outputs are idle: `data_en_n`=1, `sync`=0, `sel_store`=0, `done`=0. The registers then hold their defaults: preamble 0, packet 64, guard 64, burst count 1, auto-repeat on, internal preamble, master mode. These give repeating bursts at 50% duty cycle.
- R2: In master mode the first symbol strobe after a `go` pulse starts a burst. A burst keeps `data_en_n` low for exactly P+N symbols (P preamble, N packet). Each symbol is the span between two strobes, and a phase ends on the strobe that closes its last symbol. The guard follows with `data_en_n` high for G symbols. Outputs change only on a clock edge that samples `sym_stb`.
- R3: A preamble length of 0 sends the burst straight into the packet phase, and `sel_store` never asserts.
- R4: `sync` is always the inverse of `data_en_n`.
- R5: With auto-repeat off and burst count K, `done` rises on the strobe that ends the guard of burst K. The block then idles, and further strobes bring no burst.
- R6: `done` clears on the clock edge that accepts the next `go` in idle.
- R7: With auto-repeat on, a new burst begins on the strobe that ends each guard, whatever the burst count.
- R8: In slave mode (control bit 2 = 1) a burst starts only on the first strobe after the edge that registers a rising `trig_in`. Without such an edge no burst starts.
- R9: In slave mode a `trig_in` rise during a burst or its guard is ignored. After the guard the block waits for a new rise.
- R10: A register write made while a burst runs takes effect only when the next burst starts.
- R11: Values are clamped on write:
  - packet length (address 1) to 1..16381
  - guard length (address 2) to 2..16382
  - burst count (address 3) to 1..10,000,000

  Preamble length (address 0) takes bits 7:0.
- R12: Control register (address 4): bit 0 auto-repeat, bit 1 external preamble source, bit 2 slave mode. With bit 1 set, `sel_store` stays low through the preamble, and `data_en_n` is still low for the preamble symbols. With bit 1 clear, `sel_store` is high exactly for the P preamble symbols.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 preamble, 1 packet, 2 guard, 3 count, 4 control) |
| wr_data | input | 24 | Register write data |
| go | input | 1 | Start command, accepted in idle only |
| sym_stb | input | 1 | One-cycle symbol strobe |
| trig_in | input | 1 | External burst trigger for slave mode |
| data_en_n | output | 1 | Active-low data enable, low during burst symbols |
| sync | output | 1 | High during burst symbols |
| sel_store | output | 1 | High while the internal preamble store supplies symbols |
| done | output | 1 | All programmed bursts sent |

## Verification
The phase outputs are decoded directly from state, and that state changes on the clock edge that samples a symbol strobe. The bench therefore raises each strobe for one cycle and reads the outputs at the falling edge that follows it. Each reading describes the symbol that strobe opened. The done flag is expected on the reading after strobe B+G+1 of a single burst, and to clear one edge after an accepted start. A trigger needs one edge to register before the strobe that uses it. The slave sequence therefore leaves one idle cycle between raising the trigger and strobing.

// File: rtl/burst_seq_ctl.sv
module burst_seq_ctl #(
  parameter int PRE_W   = 8,
  parameter int LEN_W   = 14,
  parameter int DW      = 24,
  parameter int AW      = 3,
  parameter int PKT_MAX = 16381,
  parameter int GRD_MIN = 2,
  parameter int GRD_MAX = 16382,
  parameter int CNT_MAX = 10000000,
  parameter int DEF_LEN = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          go,
  input  logic          sym_stb,
  input  logic          trig_in,
  output logic          data_en_n,
  output logic          sync,
  output logic          sel_store,
  output logic          done
);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_PRE, S_DATA, S_GRD} st_t;

  st_t              state;
  logic [PRE_W-1:0] pre_sh, act_pre;
  logic [LEN_W-1:0] pkt_sh, act_pkt, grd_sh, act_grd, sym_cnt;
  logic [DW-1:0]    cnt_sh, act_cnt, bcnt;
  logic             auto_sh, ext_sh, slave_sh, act_auto, act_ext;
  logic             trig_q, pend;

  wire trig_rise = trig_in & ~trig_q;
  wire [LEN_W-1:0] pre_last = LEN_W'(act_pre) - LEN_W'(1);
  wire [LEN_W-1:0] pkt_last = act_pkt - LEN_W'(1);
  wire [LEN_W-1:0] grd_last = act_grd - LEN_W'(1);
  wire more      = act_auto | (bcnt < act_cnt);
  wire grd_end   = sym_stb && state == S_GRD && sym_cnt == grd_last;
  wire wait_go   = sym_stb && state == S_WAIT && (!slave_sh || pend);
  wire start     = wait_go || (grd_end && more && !slave_sh);

  assign data_en_n = !(state == S_PRE || state == S_DATA);
  assign sync      = !data_en_n;
  assign sel_store = (state == S_PRE) && !act_ext;

  // shadow registers with write-time clamping
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_sh   <= '0;
      pkt_sh   <= LEN_W'(DEF_LEN);
      grd_sh   <= LEN_W'(DEF_LEN);
      cnt_sh   <= DW'(1);
      auto_sh  <= 1'b1;
      ext_sh   <= 1'b0;
      slave_sh <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        AW'(0): pre_sh <= wr_data[PRE_W-1:0];
        AW'(1): begin
          if (wr_data == '0)                pkt_sh <= LEN_W'(1);
          else if (wr_data > DW'(PKT_MAX))  pkt_sh <= LEN_W'(PKT_MAX);
          else                              pkt_sh <= wr_data[LEN_W-1:0];
        end
        AW'(2): begin
          if (wr_data < DW'(GRD_MIN))       grd_sh <= LEN_W'(GRD_MIN);
          else if (wr_data > DW'(GRD_MAX))  grd_sh <= LEN_W'(GRD_MAX);
          else                              grd_sh <= wr_data[LEN_W-1:0];
        end
        AW'(3): begin
          if (wr_data == '0)                cnt_sh <= DW'(1);
          else if (wr_data > DW'(CNT_MAX))  cnt_sh <= DW'(CNT_MAX);
          else                              cnt_sh <= wr_data;
        end
        AW'(4): begin
          auto_sh  <= wr_data[0];
          ext_sh   <= wr_data[1];
          slave_sh <= wr_data[2];
        end
        default: ;
      endcase
    end
  end

  // trigger edge capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      trig_q <= trig_in;
      if (state != S_WAIT || start) pend <= 1'b0;
      else if (trig_rise)           pend <= 1'b1;
    end
  end

  // sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      sym_cnt  <= '0;
      bcnt     <= '0;
      done     <= 1'b0;
      act_pre  <= '0;
      act_pkt  <= LEN_W'(DEF_LEN);
      act_grd  <= LEN_W'(DEF_LEN);
      act_cnt  <= DW'(1);
      act_auto <= 1'b1;
      act_ext  <= 1'b0;
    end else if (start) begin
      act_pre  <= pre_sh;
      act_pkt  <= pkt_sh;
      act_grd  <= grd_sh;
      act_cnt  <= cnt_sh;
      act_auto <= auto_sh;
      act_ext  <= ext_sh;
      sym_cnt  <= '0;
      if (bcnt != '1) bcnt <= bcnt + DW'(1);
      state    <= (pre_sh != '0) ? S_PRE : S_DATA;
    end else begin
      case (state)
        S_IDLE: if (go) begin
          state <= S_WAIT;
          done  <= 1'b0;
          bcnt  <= '0;
        end
        S_PRE: if (sym_stb) begin
          if (sym_cnt == pre_last) begin
            state   <= S_DATA;
            sym_cnt <= '0;
          end else sym_cnt <= sym_cnt + LEN_W'(1);
        end
        S_DATA: if (sym_stb) begin
          if (sym_cnt == pkt_last) begin
            state   <= S_GRD;
            sym_cnt <= '0;
          end else sym_cnt <= sym_cnt + LEN_W'(1);
        end
        S_GRD: if (sym_stb) begin
          if (grd_end) begin
            sym_cnt <= '0;
            if (!more) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end else state <= S_WAIT;
          end else sym_cnt <= sym_cnt + LEN_W'(1);
        end
        default: ;
      endcase
    end
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_stb |=> $stable(data_en_n));

  // R12
  store_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_store |-> !data_en_n);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> data_en_n);

  // R6
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && state == S_IDLE) |=> !done);

  // R8
  slave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_sh && state == S_WAIT && !pend) |=> data_en_n);

  // R11
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_sh >= LEN_W'(1) && pkt_sh <= LEN_W'(PKT_MAX) &&
    grd_sh >= LEN_W'(GRD_MIN) && grd_sh <= LEN_W'(GRD_MAX) &&
    cnt_sh >= DW'(1) && cnt_sh <= DW'(CNT_MAX));

endmodule

// File: tb/test_burst_seq_ctl.sv
module test_burst_seq_ctl;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, go = 1'b0, sym_stb = 1'b0, trig_in = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [23:0] wr_data = '0;
  logic data_en_n, sync, sel_store, done;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  burst_seq_ctl i_burst_seq_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .go(go), .sym_stb(sym_stb), .trig_in(trig_in),
    .data_en_n(data_en_n), .sync(sync), .sel_store(sel_store), .done(done));

  // pre, pkt, grd, ext, expected burst, expected guard, expected store symbols
  localparam int NV = 5;
  localparam int VEC [NV][7] = '{
    '{3,   5,     4,     0, 8,     4,     3},
    '{0,   6,     6,     0, 6,     6,     0},
    '{4,   2,     3,     1, 6,     3,     0},
    '{0,   0,     1,     0, 1,     2,     0},
    '{255, 20000, 20000, 0, 16636, 16382, 255}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'(a); wr_data = 24'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_go();
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk); sym_stb = 1'b1;
    @(negedge clk); sym_stb = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int bad, lows, stores, syncbad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(data_en_n == 1'b1 && sync == 1'b0 && sel_store == 1'b0 && done == 1'b0,
        "R1 idle outputs", {data_en_n, sync, sel_store, done}, 4'b1000);

    // table of single bursts, auto-repeat off, count written 0 (clamps to 1)
    for (int v = 0; v < NV; v++) begin
      wr(0, VEC[v][0]); wr(1, VEC[v][1]); wr(2, VEC[v][2]); wr(3, 0);
      wr(4, VEC[v][3] * 2);
      pulse_go();
      bad = 0; lows = 0; stores = 0; syncbad = 0;
      for (int k = 1; k <= VEC[v][4] + VEC[v][5]; k++) begin
        strobe();
        if ((data_en_n == 1'b0) != (k <= VEC[v][4])) bad++;
        if (!data_en_n) lows++;
        if (sel_store != (k <= VEC[v][6])) bad++;
        if (sel_store) stores++;
        if (sync != !data_en_n) syncbad++;
        if (done) bad++;
      end
      chk(bad == 0, "R2 R3 R11 burst shape", lows, VEC[v][4]);
      chk(stores == VEC[v][6], "R12 R3 store select", stores, VEC[v][6]);
      chk(syncbad == 0, "R4 sync inverse", syncbad, 0);
      strobe();
      chk(done == 1'b1 && data_en_n == 1'b1, "R5 R11 done after one burst", done, 1);
    end
    strobe(); strobe();
    chk(data_en_n == 1'b1 && done == 1'b1, "R5 no burst after done", data_en_n, 1);
    pulse_go();
    chk(done == 1'b0, "R6 done cleared by go", done, 0);

    // defaults: 64/64 with auto-repeat
    do_reset();
    pulse_go();
    bad = 0;
    for (int k = 1; k <= 129; k++) begin
      strobe();
      if ((data_en_n == 1'b0) != (k <= 64 || k == 129)) bad++;
      if (done) bad++;
    end
    chk(bad == 0, "R1 R7 default repeating bursts", bad, 0);

    // finite count of three bursts
    do_reset();
    wr(0, 2); wr(1, 3); wr(2, 2); wr(3, 3); wr(4, 0);
    pulse_go();
    lows = 0; bad = 0;
    for (int k = 1; k <= 21; k++) begin
      strobe();
      if (!data_en_n) lows++;
      if (done) bad++;
    end
    chk(lows == 15 && bad == 0, "R5 three bursts sent", lows, 15);
    strobe();
    chk(done == 1'b1, "R5 done after third guard", done, 1);

    // write during a burst
    do_reset();
    wr(1, 4); wr(2, 2);
    pulse_go();
    strobe();
    wr(1, 2);
    bad = 0;
    for (int k = 2; k <= 9; k++) begin
      strobe();
      if ((data_en_n == 1'b0) != (k <= 4 || k == 7 || k == 8)) bad++;
    end
    chk(bad == 0, "R10 write applies to next burst", bad, 0);

    // slave mode
    do_reset();
    wr(1, 3); wr(2, 2); wr(3, 2); wr(4, 4);
    pulse_go();
    bad = 0;
    for (int k = 0; k < 3; k++) begin
      strobe();
      if (!data_en_n) bad++;
    end
    chk(bad == 0, "R8 no burst without trigger", bad, 0);
    @(negedge clk); trig_in = 1'b1;
    strobe();
    chk(data_en_n == 1'b0, "R8 burst after trigger", data_en_n, 0);
    strobe();
    @(negedge clk); trig_in = 1'b0;
    @(negedge clk); trig_in = 1'b1;
    strobe();
    chk(data_en_n == 1'b0, "R8 burst third symbol", data_en_n, 0);
    strobe(); strobe(); strobe();
    bad = 0;
    for (int k = 0; k < 3; k++) begin
      strobe();
      if (!data_en_n) bad++;
    end
    chk(bad == 0 && done == 1'b0, "R9 trigger during burst ignored", bad, 0);
    @(negedge clk); trig_in = 1'b0;
    @(negedge clk); trig_in = 1'b1;
    bad = 0;
    for (int k = 1; k <= 5; k++) begin
      strobe();
      if ((data_en_n == 1'b0) != (k <= 3)) bad++;
    end
    chk(bad == 0, "R8 second triggered burst", bad, 0);
    strobe();
    chk(done == 1'b1, "R5 slave done after count", done, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule